// File: doc/BRIEF.md
# Pipelined Instruction Fetch Sequencer

This block drives program flow for a small 8-bit controller with separate program and data memories. It holds the program counter and presents it on a 15-bit program address bus. The 14-bit word that memory returns is captured at the end of each instruction cycle and moved into an execute register. Each instruction cycle lasts four clocks, and a one-clock `cyc_en` pulse marks its last clock. Because the next word is fetched while the current one executes, straight-line code completes one instruction per instruction cycle.

The execute stage decodes the word in `exec_instr` and returns three flow flags (call, return, goto) together with a target address. These flags are sampled on the `cyc_en` clock. Any change of flow throws away the word fetched in parallel, so the following instruction cycle is a flush: `exec_valid` is low and `exec_instr` is zero. A taken branch therefore costs two instruction cycles. Calls and interrupts push a return address onto a 16-entry hardware stack, and returns pop it. An interrupt request is accepted only on an instruction-cycle boundary and sends the fetch to the fixed vector 0x0004. Reset starts the fetch at 0x0000.

The sequencer has two states. In `S_FILL` the execute register holds no instruction. This is the state after reset and during every flush. In `S_EXEC` the execute register holds a live instruction. The transitions happen only on `cyc_en`:
- fill-to-exec: the fetched word arrives and no interrupt is taken.
- fill-to-fill: an interrupt is taken while filling.
- exec-to-exec: sequential flow.
- exec-to-fill: call, return, goto or interrupt.

Top module: `fetch_sequencer`

## Requirements
- R1: `cyc_en` is high for exactly one clock in every four. Its first pulse is on the fourth clock after reset is released.
- R2: While reset is held low, `pmem_addr` is 0x0000, `exec_valid` is 0, `exec_instr` is 0, `irq_ack` is 0 and both stack flags are 0.
- R3: On a `cyc_en` clock with no redirect, the word on `pmem_rdata` moves into `exec_instr`, `exec_valid` becomes 1 and `pmem_addr` increments by one.
- R4: When `exec_valid` is 1 and `flow_call` is 1 on a `cyc_en` clock, the current `pmem_addr` is pushed, `pmem_addr` loads `flow_target`, and the next instruction cycle is a flush (`exec_valid` 0, `exec_instr` 0).
- R5: When `exec_valid` is 1 and `flow_goto` is 1 on a `cyc_en` clock, `pmem_addr` loads `flow_target` without touching the stack, followed by a flush.
- R6: When `exec_valid` is 1 and `flow_ret` is 1 on a `cyc_en` clock with a non-empty stack, the most recently pushed address is popped into `pmem_addr`, followed by a flush.
- R7: The flow flags are ignored while `exec_valid` is 0. If more than one flag is high, call wins over return and return wins over goto.
- R8: `irq_req` is accepted on a `cyc_en` clock unless a live call, return or goto is executing. On acceptance `irq_ack` pulses with `cyc_en`, the current `pmem_addr` is pushed, the fetch goes to 0x0004, and a flush follows.
- R9: A push onto a stack that already holds 16 entries discards the oldest entry and sets the sticky `stk_overflow`.
- R10: A return on an empty stack sets the sticky `stk_underflow`, loads 0x0000 into `pmem_addr` and leaves the stack empty.
- R11: `pmem_addr` changes only on the clock right after a `cyc_en` clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pmem_addr | output | 15 | Program memory address (program counter) |
| pmem_rdata | input | 14 | Instruction word returned for `pmem_addr` |
| cyc_en | output | 1 | Last clock of each instruction cycle |
| exec_instr | output | 14 | Instruction in the execute stage, zero during a flush |
| exec_valid | output | 1 | Execute stage holds a live instruction |
| flow_call | input | 1 | Executing instruction is a call |
| flow_ret | input | 1 | Executing instruction is a return |
| flow_goto | input | 1 | Executing instruction is a goto |
| flow_target | input | 15 | Destination of a call or goto |
| irq_req | input | 1 | Interrupt request, sampled on `cyc_en` |
| irq_ack | output | 1 | Interrupt accepted on this clock |
| stk_overflow | output | 1 | Sticky: push onto a full stack |
| stk_underflow | output | 1 | Sticky: pop from an empty stack |

## Verification
Two events can arrive on the same boundary: an interrupt request and a live flow instruction, and likewise an interrupt request and a flush cycle. The bench holds `irq_req` high for one instruction cycle in every eleven, while a program of calls, returns and gotos runs. Over the run, requests land on call, return and goto boundaries and on flush boundaries. A behavioural model built on a queue decides on each boundary whether the request is deferred or taken, and what is pushed. It compares address, execute word, ack and stack flags on every clock. A chain of seventeen nested calls that unwinds past empty drives the stack to both of its limits while interrupts keep arriving.

// File: rtl/fs_pkg.sv
package fs_pkg;

    typedef enum logic [0:0] {
        S_FILL = 1'b0,
        S_EXEC = 1'b1
    } fs_state_e;

    typedef enum logic [2:0] {
        NX_SEQ,
        NX_IRQ,
        NX_CALL,
        NX_RET,
        NX_GOTO
    } fs_next_e;

endpackage

// File: rtl/fs_phase_ctr.sv
module fs_phase_ctr #(
    parameter int unsigned PHASES = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic cyc_en
);
    localparam int unsigned PW = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign cyc_en = (phase_q == LAST);

    // R1
    cyc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_en |=> !cyc_en);

endmodule

// File: rtl/fs_ret_stack.sv
module fs_ret_stack #(
    parameter int unsigned AW    = 15,
    parameter int unsigned DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_data,
    output logic [AW-1:0] top_data,
    output logic          empty,
    output logic          ovf,
    output logic          unf
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [AW-1:0] slot [DEPTH];
    logic [PW-1:0] sp_q;
    logic [PW:0]   cnt_q;
    logic [PW-1:0] sp_inc, sp_dec;
    logic          full;

    assign full   = (cnt_q == (PW+1)'(DEPTH));
    assign empty  = (cnt_q == '0);
    assign sp_inc = (sp_q == LAST) ? '0 : sp_q + 1'b1;
    assign sp_dec = (sp_q == '0) ? LAST : sp_q - 1'b1;
    assign top_data = slot[sp_dec];

    always_ff @(posedge clk) begin
        if (push)
            slot[sp_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q  <= '0;
            cnt_q <= '0;
            ovf   <= 1'b0;
            unf   <= 1'b0;
        end else if (push) begin
            sp_q <= sp_inc;
            if (full)
                ovf <= 1'b1;
            else
                cnt_q <= cnt_q + 1'b1;
        end else if (pop) begin
            if (empty) begin
                unf <= 1'b1;
            end else begin
                sp_q  <= sp_dec;
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R9
    full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> (ovf && !empty));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> (unf && empty));

    // R10
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf |=> unf);

endmodule

// File: rtl/fs_next_pc.sv
module fs_next_pc
    import fs_pkg::*;
#(
    parameter int unsigned AW        = 15,
    parameter int unsigned RESET_VEC = 0,
    parameter int unsigned IRQ_VEC   = 4
) (
    input  logic          exec_live,
    input  logic          call,
    input  logic          ret,
    input  logic          jump,
    input  logic          irq,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] target,
    input  logic [AW-1:0] stk_top,
    input  logic          stk_empty,
    output logic [AW-1:0] next_pc,
    output logic          push,
    output logic          pop,
    output logic          redirect,
    output logic          take_irq
);
    fs_next_e sel;
    logic     any_flow;

    assign any_flow = exec_live & (call | ret | jump);
    assign take_irq = irq & ~any_flow;

    always_comb begin
        if (take_irq)
            sel = NX_IRQ;
        else if (exec_live && call)
            sel = NX_CALL;
        else if (exec_live && ret)
            sel = NX_RET;
        else if (exec_live && jump)
            sel = NX_GOTO;
        else
            sel = NX_SEQ;
    end

    always_comb begin
        next_pc  = pc + 1'b1;
        push     = 1'b0;
        pop      = 1'b0;
        redirect = 1'b1;
        unique case (sel)
            NX_SEQ: begin
                redirect = 1'b0;
            end
            NX_IRQ: begin
                next_pc = AW'(IRQ_VEC);
                push    = 1'b1;
            end
            NX_CALL: begin
                next_pc = target;
                push    = 1'b1;
            end
            NX_RET: begin
                next_pc = stk_empty ? AW'(RESET_VEC) : stk_top;
                pop     = 1'b1;
            end
            NX_GOTO: begin
                next_pc = target;
            end
            default: begin
                redirect = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
    import fs_pkg::*;
#(
    parameter int unsigned ADDR_W      = 15,
    parameter int unsigned INSTR_W     = 14,
    parameter int unsigned STACK_DEPTH = 16,
    parameter int unsigned PHASES      = 4,
    parameter int unsigned RESET_VEC   = 0,
    parameter int unsigned IRQ_VEC     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [ADDR_W-1:0]  pmem_addr,
    input  logic [INSTR_W-1:0] pmem_rdata,
    output logic               cyc_en,
    output logic [INSTR_W-1:0] exec_instr,
    output logic               exec_valid,
    input  logic               flow_call,
    input  logic               flow_ret,
    input  logic               flow_goto,
    input  logic [ADDR_W-1:0]  flow_target,
    input  logic               irq_req,
    output logic               irq_ack,
    output logic               stk_overflow,
    output logic               stk_underflow
);
    fs_state_e          state_q, state_d;
    logic [ADDR_W-1:0]  pc_q, next_pc, stk_top;
    logic [INSTR_W-1:0] instr_q;
    logic               push, pop, redirect, take_irq, stk_empty;

    fs_phase_ctr #(.PHASES(PHASES)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .cyc_en (cyc_en)
    );

    fs_next_pc #(
        .AW        (ADDR_W),
        .RESET_VEC (RESET_VEC),
        .IRQ_VEC   (IRQ_VEC)
    ) u_next (
        .exec_live (state_q == S_EXEC),
        .call      (flow_call),
        .ret       (flow_ret),
        .jump      (flow_goto),
        .irq       (irq_req),
        .pc        (pc_q),
        .target    (flow_target),
        .stk_top   (stk_top),
        .stk_empty (stk_empty),
        .next_pc   (next_pc),
        .push      (push),
        .pop       (pop),
        .redirect  (redirect),
        .take_irq  (take_irq)
    );

    fs_ret_stack #(.AW(ADDR_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (cyc_en & push),
        .pop       (cyc_en & pop),
        .push_data (pc_q),
        .top_data  (stk_top),
        .empty     (stk_empty),
        .ovf       (stk_overflow),
        .unf       (stk_underflow)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_FILL;
        else
            state_q <= state_d;
    end

    // Transitions, taken only on the last clock of an instruction cycle
    always_comb begin
        state_d = state_q;
        if (cyc_en) begin
            unique case (state_q)
                S_FILL: state_d = redirect ? S_FILL : S_EXEC;
                S_EXEC: state_d = redirect ? S_FILL : S_EXEC;
                default: state_d = S_FILL;
            endcase
        end
    end

    // Program counter and execute register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= ADDR_W'(RESET_VEC);
            instr_q <= '0;
        end else if (cyc_en) begin
            pc_q    <= next_pc;
            instr_q <= redirect ? '0 : pmem_rdata;
        end
    end

    assign pmem_addr  = pc_q;
    assign exec_instr = instr_q;
    assign exec_valid = (state_q == S_EXEC);
    assign irq_ack    = cyc_en & take_irq;

    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |=> $stable(pmem_addr));

    // R4
    call_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && exec_valid && flow_call) |=> (!exec_valid && exec_instr == '0));

    // R7
    fill_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && !exec_valid && !irq_req) |=> exec_valid);

    // R8
    irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (pmem_addr == ADDR_W'(IRQ_VEC) && !exec_valid));

endmodule

// File: tb/fetch_sequencer_tb.sv
`timescale 1ns/1ps
module fetch_sequencer_tb;

    localparam int LVL_BASE = 'h100;
    localparam int LVL_STEP = 'h20;
    localparam int LVL_LAST = 17;
    localparam int RUN_CLKS = 1800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] pmem_addr;
    logic [13:0] pmem_rdata;
    logic        cyc_en;
    logic [13:0] exec_instr;
    logic        exec_valid;
    logic        flow_call, flow_ret, flow_goto;
    logic [14:0] flow_target;
    logic        irq_req = 1'b0;
    logic        irq_ack, stk_overflow, stk_underflow;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // Bench program: op in [13:12] 00 plain, 01 call, 10 return, 11 goto; target in [11:0]
    function automatic logic [13:0] prog_word(int a);
        int off, lvl;
        if (a == 0)      return {2'b11, 12'h010};
        if (a == 5)      return {2'b10, 12'h000};
        if (a == 'h12)   return {2'b01, 12'h040};
        if (a == 'h13)   return {2'b11, 12'(LVL_BASE)};
        if (a == 'h41)   return {2'b01, 12'h080};
        if (a == 'h42)   return {2'b10, 12'h000};
        if (a == 'h80)   return {2'b10, 12'h000};
        if (a >= LVL_BASE && a <= LVL_BASE + LVL_STEP * LVL_LAST + 1) begin
            off = (a - LVL_BASE) % LVL_STEP;
            lvl = (a - LVL_BASE) / LVL_STEP;
            if (off == 0 && lvl < LVL_LAST)
                return {2'b01, 12'(LVL_BASE + LVL_STEP * (lvl + 1))};
            if (off == 0 || off == 1)
                return {2'b10, 12'h000};
        end
        return {2'b00, 12'(a)};
    endfunction

    assign pmem_rdata  = prog_word(int'(pmem_addr));
    // flags decoded from the execute word; call is forced high while the stage is empty (R7)
    assign flow_call   = (exec_valid && exec_instr[13:12] == 2'b01) || !exec_valid;
    assign flow_ret    = exec_valid && exec_instr[13:12] == 2'b10;
    assign flow_goto   = exec_valid && exec_instr[13:12] == 2'b11;
    assign flow_target = {3'b000, exec_instr[11:0]};

    fetch_sequencer u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pmem_addr     (pmem_addr),
        .pmem_rdata    (pmem_rdata),
        .cyc_en        (cyc_en),
        .exec_instr    (exec_instr),
        .exec_valid    (exec_valid),
        .flow_call     (flow_call),
        .flow_ret      (flow_ret),
        .flow_goto     (flow_goto),
        .flow_target   (flow_target),
        .irq_req       (irq_req),
        .irq_ack       (irq_ack),
        .stk_overflow  (stk_overflow),
        .stk_underflow (stk_underflow)
    );

    task automatic chk(string what, int actual, int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", what, actual, expected, $time);
        end
    endtask

    // reference model state
    int       m_phase = 0;
    int       m_pc = 0;
    int       m_exec = 0;
    bit       m_valid = 0;
    bit       m_ovf = 0;
    bit       m_unf = 0;
    int       m_stack[$];
    int       m_icyc = 0;
    int       irq_taken = 0;

    task automatic m_push(int v);
        if (m_stack.size() == 16) begin
            void'(m_stack.pop_front());
            m_ovf = 1;
        end
        m_stack.push_back(v);
    endtask

    initial begin
        // R2 reset state
        repeat (3) @(negedge clk);
        chk("R2 pmem_addr in reset", int'(pmem_addr), 0);
        chk("R2 exec_valid in reset", int'(exec_valid), 0);
        chk("R2 exec_instr in reset", int'(exec_instr), 0);
        chk("R2 irq_ack in reset", int'(irq_ack), 0);
        chk("R2 stack flags in reset", int'({stk_overflow, stk_underflow}), 0);
        rst_n = 1'b1;
        for (int n = 0; n < RUN_CLKS; n++) begin
            bit live, mc, mr, mg, take;
            int op, fetched;
            if (m_phase == 0)
                irq_req = (m_icyc % 11 == 7);
            #1;
            chk("R11 R3 R4 R5 R6 pmem_addr", int'(pmem_addr), m_pc);
            chk("R3 R7 exec_valid", int'(exec_valid), int'(m_valid));
            chk("R3 exec_instr", int'(exec_instr), m_exec);
            chk("R1 cyc_en", int'(cyc_en), int'(m_phase == 3));
            chk("R9 stk_overflow", int'(stk_overflow), int'(m_ovf));
            chk("R10 stk_underflow", int'(stk_underflow), int'(m_unf));
            live = m_valid;
            op   = (m_exec >> 12) & 3;
            mc   = live && op == 1;
            mr   = live && op == 2;
            mg   = live && op == 3;
            take = irq_req && !(mc || mr || mg);
            chk("R8 irq_ack", int'(irq_ack), int'(m_phase == 3 && take));
            if (m_phase == 3) begin
                fetched = int'(prog_word(m_pc));
                if (take) begin
                    irq_taken++;
                    m_push(m_pc);
                    m_pc = 4;
                end else if (mc) begin
                    m_push(m_pc);
                    m_pc = m_exec & 'hFFF;
                end else if (mr) begin
                    if (m_stack.size() == 0) begin
                        m_unf = 1;
                        m_pc = 0;
                    end else begin
                        m_pc = m_stack.pop_back();
                    end
                end else if (mg) begin
                    m_pc = m_exec & 'hFFF;
                end
                if (take || mc || mr || mg) begin
                    m_valid = 0;
                    m_exec = 0;
                end else begin
                    m_valid = 1;
                    m_exec = fetched;
                    m_pc = (m_pc + 1) & 'h7FFF;
                end
                m_icyc++;
            end
            m_phase = (m_phase + 1) % 4;
            @(negedge clk);
        end
        // the run must have reached both stack limits and taken interrupts
        chk("R9 overflow reached", int'(stk_overflow), 1);
        chk("R10 underflow reached", int'(stk_underflow), 1);
        chk("R8 interrupts taken", int'(irq_taken > 3), 1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #((RUN_CLKS + 200) * 4);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule